// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Line Bypass

This block collects up to 32 level-sensitive interrupt lines and reduces them onto a small number of grouped request outputs for a parent interrupt controller. Each grouped output owns a static membership mask. It raises its request when at least one member line is high and also enabled in the single shared enable word. A static forward mask picks lines that skip the aggregation entirely: each such line drives its own dedicated output, whatever its enable bit holds.

Software sees two 32-bit words. The enable word at offset 0x0 is read/write. The status word at offset 0x4 is read-only and shows the level of every connected line. There is no set/clear aliasing, so software changes the enable word with a full read-modify-write. Lines that belong to no group mask and are not forwarded count as unconnected. They never reach any output and read as zero in the status word. An optional wake output flags any enabled, aggregated line and exists only when the configuration marks the block as wake-capable. Every request output is registered once so that no glitch from the OR trees reaches the parent.

Top module: `l2_irq_aggregator`

## Requirements
- R1: After reset the enable word reads 0 and grp_irq, fwd_irq and wake_irq are all 0.
- R2: A write to byte offset 0x0 stores bus_wdata into the enable word. A read of offset 0x0 returns the stored value on bus_rdata one clock after the cycle bus_rd is high.
- R3: A read of offset 0x4 returns the levels that irq_in had one clock earlier, for connected lines only.
- R4: A write to offset 0x4 has no effect: the enable word read back afterwards is unchanged.
- R5: grp_irq[k] is 1 one clock after any line that is set in group mask k, not forwarded, high and enabled. Otherwise grp_irq[k] is 0.
- R6: A line set in the forward mask drives fwd_irq at the same bit position one clock later, whatever its enable bit holds. It never raises grp_irq or wake_irq.
- R7: fwd_irq bits whose forward-mask bit is 0 stay 0.
- R8: Lines set in no group mask and not forwarded (bits 12 to 31 with the default masks) never raise any output, and they read as 0 in the status word.
- R9: With the wake-capable flag set, wake_irq is 1 one clock after any enabled, non-forwarded, group-member line is high. Otherwise wake_irq is 0.
- R10: A read of any offset other than 0x0 or 0x4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | N_IN | Level-sensitive interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | N_IN | Write data |
| bus_rdata | output | N_IN | Registered read data |
| grp_irq | output | N_GRP | Grouped requests toward the parent controller |
| fwd_irq | output | N_IN | Per-line bypass requests for forwarded lines |
| wake_irq | output | 1 | Wake request for enabled aggregated lines |

## Verification
The assertions assume three things. The bus never raises bus_rd and bus_wr in the same cycle. Addresses and strobes are stable around the clock edge. irq_in is already synchronous to clk. The stimulus keeps to these limits: it changes every input only on the falling edge, issues exactly one access per task and holds the lines steady across each status read. The group-mask and forward-mask defaults are assumed not to overlap, and every test uses those defaults.

// File: rtl/l2_agg_pkg.sv
package l2_agg_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] OFS_ENABLE = 3'h0;
  localparam logic [REG_ADDR_W-1:0] OFS_STATUS = 3'h4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/l2_agg_rst_sync.sv
module l2_agg_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/l2_agg_regs.sv
module l2_agg_regs
  import l2_agg_pkg::*;
#(
  parameter int unsigned N_IN   = 32,
  parameter int unsigned ADDR_W = REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_IN-1:0]   bus_wdata,
  input  logic [N_IN-1:0]   irq_in,
  input  logic [N_IN-1:0]   conn_mask,
  output logic [N_IN-1:0]   en_q,
  output logic [N_IN-1:0]   status_q,
  output logic [N_IN-1:0]   bus_rdata
);

  reg_sel_e        sel;
  logic            en_ld;
  logic [N_IN-1:0] en_d;
  logic [N_IN-1:0] status_d;
  logic [N_IN-1:0] rdata_d;
  logic [N_IN-1:0] rdata_q;

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_ENABLE)) begin
      sel = SEL_ENABLE;
    end else if (bus_addr == ADDR_W'(OFS_STATUS)) begin
      sel = SEL_STATUS;
    end
  end

  // next state
  always_comb begin
    en_ld    = bus_wr && (sel == SEL_ENABLE);
    en_d     = bus_wdata;
    status_d = irq_in & conn_mask;
    case (sel)
      SEL_ENABLE: rdata_d = en_q;
      SEL_STATUS: rdata_d = status_q;
      default:    rdata_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ld) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ENABLE)) |=> (en_q == $past(bus_wdata))); // R2

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_STATUS)) |=> $stable(en_q)); // R4

  AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != ADDR_W'(OFS_ENABLE) && bus_addr != ADDR_W'(OFS_STATUS))
      |=> (bus_rdata == '0)); // R10

endmodule

// File: rtl/l2_agg_route.sv
module l2_agg_route #(
  parameter int unsigned                       N_IN         = 32,
  parameter int unsigned                       N_GRP        = 2,
  parameter logic [N_GRP-1:0][N_IN-1:0]        MAP_MASK     = '0,
  parameter logic [N_IN-1:0]                   FWD_MASK     = '0,
  parameter logic [N_IN-1:0]                   AGG_CONN     = '0,
  parameter bit                                WAKE_CAPABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  irq_in,
  input  logic [N_IN-1:0]  en_q,
  output logic [N_GRP-1:0] grp_q,
  output logic [N_IN-1:0]  fwd_q,
  output logic             wake_q
);

  logic [N_IN-1:0]  agg_src;
  logic [N_GRP-1:0] grp_d;
  logic [N_IN-1:0]  fwd_d;
  logic             wake_d;

  // lines on the aggregated path: not forwarded, enabled, high
  always_comb begin
    agg_src = irq_in & en_q & ~FWD_MASK;
    fwd_d   = irq_in & FWD_MASK;
  end

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    always_comb begin
      grp_d[k] = |(agg_src & MAP_MASK[k]);
    end

    AST_GRP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_q[k] |-> $past(|(en_q & MAP_MASK[k] & ~FWD_MASK))); // R5
  end

  if (WAKE_CAPABLE) begin : g_wake
    always_comb begin
      wake_d = |(agg_src & AGG_CONN);
    end
  end else begin : g_no_wake
    always_comb begin
      wake_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      fwd_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      grp_q  <= grp_d;
      fwd_q  <= fwd_d;
      wake_q <= wake_d;
    end
  end

  AST_WAKE_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (|grp_q)); // R9

  AST_FWD_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_q & ~$past(irq_in)) == '0)); // R6

  AST_FWD_OUTSIDE_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_q & ~FWD_MASK) == '0)); // R7

endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator
  import l2_agg_pkg::*;
#(
  parameter int unsigned                N_IN         = 32,
  parameter int unsigned                N_GRP        = 2,
  parameter int unsigned                ADDR_W       = REG_ADDR_W,
  parameter logic [N_GRP-1:0][N_IN-1:0] MAP_MASK     = {32'h0000_0140, 32'h0000_0EB8},
  parameter logic [N_IN-1:0]            FWD_MASK     = 32'h0000_0007,
  parameter bit                         WAKE_CAPABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_IN-1:0]   bus_wdata,
  output logic [N_IN-1:0]   bus_rdata,
  output logic [N_GRP-1:0]  grp_irq,
  output logic [N_IN-1:0]   fwd_irq,
  output logic              wake_irq
);

  function automatic logic [N_IN-1:0] fold_maps();
    logic [N_IN-1:0] acc;
    acc = '0;
    for (int k = 0; k < N_GRP; k++) begin
      acc = acc | MAP_MASK[k];
    end
    return acc;
  endfunction

  localparam logic [N_IN-1:0] AGG_CONN  = fold_maps();
  localparam logic [N_IN-1:0] CONN_MASK = AGG_CONN | FWD_MASK;

  logic            rst_n_sync;
  logic [N_IN-1:0] en_q;
  logic [N_IN-1:0] status_q;

  l2_agg_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  l2_agg_regs #(
    .N_IN   (N_IN),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_in    (irq_in),
    .conn_mask (CONN_MASK),
    .en_q      (en_q),
    .status_q  (status_q),
    .bus_rdata (bus_rdata)
  );

  l2_agg_route #(
    .N_IN         (N_IN),
    .N_GRP        (N_GRP),
    .MAP_MASK     (MAP_MASK),
    .FWD_MASK     (FWD_MASK),
    .AGG_CONN     (AGG_CONN),
    .WAKE_CAPABLE (WAKE_CAPABLE)
  ) u_route (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .irq_in (irq_in),
    .en_q   (en_q),
    .grp_q  (grp_irq),
    .fwd_q  (fwd_irq),
    .wake_q (wake_irq)
  );

  AST_STATUS_UNCONN_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $past(bus_rd && bus_addr == ADDR_W'(OFS_STATUS)) |-> ((bus_rdata & ~CONN_MASK) == '0)); // R8

  AST_UNCONN_NO_GROUP: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past((irq_in & CONN_MASK) == '0)) |-> (grp_irq == '0 && fwd_irq == '0 && !wake_irq)); // R8

  AST_FWD_NOT_GROUPED: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past((irq_in & ~FWD_MASK) == '0)) |-> (grp_irq == '0 && !wake_irq)); // R6

endmodule

// File: tb/l2_irq_aggregator_tb.sv
module l2_irq_aggregator_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N_IN  = 32;
  localparam int unsigned N_GRP = 2;

  logic              clk;
  logic              rst_n;
  logic [N_IN-1:0]   irq_in;
  logic              bus_wr;
  logic              bus_rd;
  logic [2:0]        bus_addr;
  logic [N_IN-1:0]   bus_wdata;
  logic [N_IN-1:0]   bus_rdata;
  logic [N_GRP-1:0]  grp_irq;
  logic [N_IN-1:0]   fwd_irq;
  logic              wake_irq;

  int checks;
  int errors;
  bit done;

  l2_irq_aggregator u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .grp_irq   (grp_irq),
    .fwd_irq   (fwd_irq),
    .wake_irq  (wake_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = addr;
    bus_wdata = data;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_rd   = 1'b1;
    bus_addr = addr;
    @(negedge clk);
    data     = bus_rdata;
    bus_rd   = 1'b0;
  endtask

  // drive lines at a falling edge, sample outputs one falling edge later
  task automatic drive_irq(input logic [31:0] lines);
    @(negedge clk);
    irq_in = lines;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    chk("R1 grp_irq", 32'(grp_irq), 32'h0);
    chk("R1 fwd_irq", fwd_irq, 32'h0);
    chk("R1 wake_irq", 32'(wake_irq), 32'h0);
    bus_read(3'h0, rd);
    chk("R1 enable after reset", rd, 32'h0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] rd;
    bus_write(3'h0, 32'hA5A5_0FF8);
    bus_read(3'h0, rd);
    chk("R2 enable readback", rd, 32'hA5A5_0FF8);
    bus_read(3'h2, rd);
    chk("R10 read offset 0x2", rd, 32'h0);
    bus_read(3'h6, rd);
    chk("R10 read offset 0x6", rd, 32'h0);
  endtask

  task automatic t_status_write_ignored();
    logic [31:0] rd;
    bus_write(3'h4, 32'hFFFF_FFFF);
    bus_read(3'h0, rd);
    chk("R4 enable after status write", rd, 32'hA5A5_0FF8);
  endtask

  task automatic t_status_read();
    logic [31:0] rd;
    drive_irq(32'hFFFF_0123);
    bus_read(3'h4, rd);
    chk("R3 R8 status read", rd, 32'h0000_0123);
    drive_irq(32'h0000_0A48);
    bus_read(3'h4, rd);
    chk("R3 status read second pattern", rd, 32'h0000_0A48);
    drive_irq(32'h0);
  endtask

  task automatic t_groups();
    bus_write(3'h0, 32'h0000_0FFF);
    drive_irq(32'h0000_0008);
    chk("R5 bit3 to group0", 32'(grp_irq), 32'h1);
    chk("R9 wake on bit3", 32'(wake_irq), 32'h1);
    drive_irq(32'h0000_0040);
    chk("R5 bit6 to group1", 32'(grp_irq), 32'h2);
    drive_irq(32'h0000_0300);
    chk("R5 bits8,9 both groups", 32'(grp_irq), 32'h3);
    drive_irq(32'h0);
    chk("R5 idle groups", 32'(grp_irq), 32'h0);
    chk("R9 idle wake", 32'(wake_irq), 32'h0);
    bus_write(3'h0, 32'h0000_0FF7);
    drive_irq(32'h0000_0008);
    chk("R5 disabled bit3", 32'(grp_irq), 32'h0);
    chk("R9 disabled bit3 no wake", 32'(wake_irq), 32'h0);
    drive_irq(32'h0);
  endtask

  task automatic t_forward();
    bus_write(3'h0, 32'h0);
    drive_irq(32'h0000_0005);
    chk("R6 forward with enable clear", fwd_irq, 32'h0000_0005);
    chk("R6 forward no group", 32'(grp_irq), 32'h0);
    bus_write(3'h0, 32'hFFFF_FFFF);
    drive_irq(32'h0000_0007);
    chk("R6 forward all three", fwd_irq, 32'h0000_0007);
    chk("R6 forward enabled no group", 32'(grp_irq), 32'h0);
    chk("R6 forward no wake", 32'(wake_irq), 32'h0);
    drive_irq(32'h0000_0FF8);
    chk("R7 non-forwarded lines", fwd_irq, 32'h0);
    drive_irq(32'h0);
  endtask

  task automatic t_unconnected();
    bus_write(3'h0, 32'hFFFF_FFFF);
    drive_irq(32'hFFFF_F000);
    chk("R8 unconnected groups", 32'(grp_irq), 32'h0);
    chk("R8 unconnected forward", fwd_irq, 32'h0);
    chk("R8 unconnected wake", 32'(wake_irq), 32'h0);
    drive_irq(32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    irq_in    = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_rw();
    t_status_write_ignored();
    t_status_read();
    t_groups();
    t_forward();
    t_unconnected();
    finish_run();
  end

endmodule